// File: doc/BRIEF.md
# Line-Synchronised Strobe Pulse Controller

This block produces a single strobe pulse for a flash or an LED, timed to the frame and line markers that the sensor timing generator supplies. Software sets an enable bit in its register file. The controller detects the 0-to-1 edge of that bit, requests that the bit be cleared, and then waits for the frame boundary. It drives the strobe for a number of lines that depends on the selected mode, then returns to idle.

There are three mode behaviours. The xenon mode waits for the frame boundary and then for the next line start. Its pulse lasts 1 to 4 lines. The paired-LED mode starts on the frame boundary and counts a 16-bit width in lines. The single-LED mode holds the strobe for exactly one frame. A polarity input selects the active level. A busy output stays high for the whole sequence.

Top module: `strb_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `strobe_o` sits at its inactive level (the complement of `pol_i`), and `busy_o` and `en_clr_o` are 0.
- R2: A sequence is accepted only when `en_i` is 1 and was 0 in the previous cycle while the block is idle. A level held at 1 never starts a second sequence.
- R3: `en_clr_o` pulses high for exactly one cycle, in the cycle after the edge was accepted, to ask the register file to clear the enable bit.
- R4: The active strobe level equals `pol_i` (1 = active high, 0 = active low). Whenever no pulse is in progress, `strobe_o` equals the inverse of `pol_i`.
- R5: Xenon mode, `mode_i` = 2'b00. The strobe goes active in the cycle after the first `line_i` pulse that comes strictly after the next `frame_i` pulse. A line pulse in the same cycle as the frame pulse does not count. With width code w on `xw_i` (00..11), the strobe stays active until the cycle after the (w+1)-th line pulse counted from the start line, so it lasts w+1 lines.
- R6: Paired-LED mode, `mode_i` = 2'b01 or 2'b10. The strobe goes active in the cycle after the next `frame_i` pulse and ends in the cycle after the `led_w_i`-th later `line_i` pulse. When `led_w_i` = 0, the sequence ends at that frame pulse without any active strobe.
- R7: Single-LED mode, `mode_i` = 2'b11. The strobe is active from the cycle after the next `frame_i` pulse until the cycle after the following `frame_i` pulse. Line pulses have no effect on it.
- R8: An enable edge that arrives while `busy_o` is 1 is ignored. It produces no `en_clr_o` and does not start a sequence after the current one ends.
- R9: `busy_o` rises in the cycle after an accepted edge and falls in the same cycle that the strobe returns to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable bit from the register file |
| pol_i | input | 1 | Active strobe level |
| mode_i | input | 2 | Mode: 00 xenon, 01/10 paired LED, 11 single LED |
| xw_i | input | XW_W | Xenon width code (lines minus one) |
| led_w_i | input | LED_W | Paired-LED width in lines |
| frame_i | input | 1 | One-cycle frame-start pulse |
| line_i | input | 1 | One-cycle line-start pulse |
| strobe_o | output | 1 | Strobe output |
| busy_o | output | 1 | Sequence in progress |
| en_clr_o | output | 1 | One-cycle request to clear the enable bit |

## Verification
Each response lands one clock edge after the stimulus that causes it. The accepting edge, each frame or line pulse, and the terminating line or frame pulse all change `busy_o`, `strobe_o` and `en_clr_o` at the next rising edge. The driver applies each cycle's inputs shortly after a rising edge and queues the outputs expected after the following edge. The monitor pops that entry one time unit after that edge, so every comparison is made exactly one register stage behind its stimulus. Coinciding frame and line pulses, early line pulses and edges during a busy sequence each get cycles of their own in the queue.

// File: rtl/strb_pkg.sv
package strb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WFRM,
      ST_WLINE,
      ST_LINES,
      ST_FRAME
   } strb_st_e;

   localparam logic [1:0] MODE_XEN  = 2'b00;
   localparam logic [1:0] MODE_LED3 = 2'b11;
endpackage

// File: rtl/strb_edge.sv
module strb_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/strb_lcnt.sv
module strb_lcnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   input  logic          tick_i,
   output logic          last_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= val_i;
      else if (tick_i) cnt_q <= cnt_q - CW'(1);
   end

   assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/strb_ctrl.sv
module strb_ctrl #(
   parameter int LED_W = 16,
   parameter int XW_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             pol_i,
   input  logic [1:0]       mode_i,
   input  logic [XW_W-1:0]  xw_i,
   input  logic [LED_W-1:0] led_w_i,
   input  logic             frame_i,
   input  logic             line_i,
   output logic             strobe_o,
   output logic             busy_o,
   output logic             en_clr_o
);
   import strb_pkg::*;

   localparam int CW = (LED_W > XW_W + 1) ? LED_W : XW_W + 1;

   if (LED_W < 1) begin : g_bad_led
      $error("LED_W must be at least 1");
   end
   if (XW_W < 1) begin : g_bad_xw
      $error("XW_W must be at least 1");
   end

   strb_st_e        st_q, st_d;
   logic            rise, accept;
   logic [1:0]      mode_q;
   logic [XW_W-1:0] xw_q;
   logic [CW-1:0]   xen_len, led_len, load_val;
   logic            load, tick, last;
   logic            is_led12;

   strb_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (en_i),
      .rise_o (rise)
   );

   assign accept   = rise && (st_q == ST_IDLE);
   assign is_led12 = (mode_q != MODE_XEN) && (mode_q != MODE_LED3);

   if (CW == LED_W) begin : g_led_direct
      assign led_len = led_w_i;
   end else begin : g_led_ext
      assign led_len = {{(CW - LED_W){1'b0}}, led_w_i};
   end

   assign xen_len = CW'(xw_q) + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         mode_q   <= MODE_XEN;
         xw_q     <= '0;
         en_clr_o <= 1'b0;
      end else begin
         st_q     <= st_d;
         en_clr_o <= accept;
         if (accept) begin
            mode_q <= mode_i;
            xw_q   <= xw_i;
         end
      end
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (accept) st_d = ST_WFRM;
         ST_WFRM:
            if (frame_i) begin
               if (mode_q == MODE_XEN)       st_d = ST_WLINE;
               else if (mode_q == MODE_LED3) st_d = ST_FRAME;
               else if (led_len == '0)       st_d = ST_IDLE;
               else                          st_d = ST_LINES;
            end
         ST_WLINE: if (line_i) st_d = ST_LINES;
         ST_LINES: if (line_i && last) st_d = ST_IDLE;
         ST_FRAME: if (frame_i) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign load     = ((st_q == ST_WFRM) && frame_i && is_led12)
                   || ((st_q == ST_WLINE) && line_i);
   assign load_val = (st_q == ST_WLINE) ? xen_len : led_len;
   assign tick     = (st_q == ST_LINES) && line_i;

   strb_lcnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .val_i  (load_val),
      .tick_i (tick),
      .last_o (last)
   );

   assign strobe_o = ((st_q == ST_LINES) || (st_q == ST_FRAME)) ? pol_i : ~pol_i;
   assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/strb_ctrl_chk.sv
module strb_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pol_i,
   input logic strobe_o,
   input logic busy_o,
   input logic en_clr_o
);
   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_o |=> !en_clr_o); // R3

   AST_CLR_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_o |-> busy_o); // R9

   AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (strobe_o == !pol_i)); // R4

   AST_NO_CLR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_o |-> !$past(busy_o)); // R8

   AST_BUSY_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> en_clr_o); // R2
endmodule

bind strb_ctrl strb_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pol_i    (pol_i),
   .strobe_o (strobe_o),
   .busy_o   (busy_o),
   .en_clr_o (en_clr_o)
);

// File: tb/sim_strb_ctrl.sv
module sim_strb_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        en_i, pol_i, frame_i, line_i;
   logic [1:0]  mode_i, xw_i;
   logic [15:0] led_w_i;
   logic        strobe_o, busy_o, en_clr_o;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   typedef struct {
      logic  act;
      logic  busy;
      logic  clr;
      string tag;
   } exp_t;

   exp_t q[$];

   always #5 clk = ~clk;

   strb_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .pol_i(pol_i), .mode_i(mode_i),
      .xw_i(xw_i), .led_w_i(led_w_i), .frame_i(frame_i), .line_i(line_i),
      .strobe_o(strobe_o), .busy_o(busy_o), .en_clr_o(en_clr_o)
   );

   task automatic step(input logic e, input logic f, input logic l,
                       input logic act, input logic bsy, input logic clr,
                       input string tag);
      @(posedge clk); #2;
      en_i = e; frame_i = f; line_i = l;
      q.push_back('{act, bsy, clr, tag});
   endtask

   task automatic setcfg(input logic p, input logic [1:0] m,
                         input logic [1:0] xw, input logic [15:0] lw);
      @(posedge clk); #2;
      pol_i = p; mode_i = m; xw_i = xw; led_w_i = lw;
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk); #1;
         if (q.size() != 0) begin
            exp_t e;
            logic exp_s;
            e = q.pop_front();
            exp_s = e.act ? pol_i : ~pol_i;
            checks++;
            if (strobe_o !== exp_s || busy_o !== e.busy || en_clr_o !== e.clr) begin
               failures++;
               $display("FAIL %s: strobe/busy/clr actual=%b%b%b expected=%b%b%b",
                        e.tag, strobe_o, busy_o, en_clr_o, exp_s, e.busy, e.clr);
            end
         end
      end
   end

   initial begin : watchdog
      #1000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog R9: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : driver
      rst_n = 1'b0; en_i = 0; pol_i = 1; frame_i = 0; line_i = 0;
      mode_i = 2'b00; xw_i = 2'd2; led_w_i = 16'd0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (strobe_o !== 1'b0 || busy_o !== 1'b0 || en_clr_o !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: actual=%b%b%b expected=000", strobe_o, busy_o, en_clr_o);
      end
      @(posedge clk); #2 rst_n = 1'b1;
      step(0,0,0, 0,0,0, "R1 after reset");

      // xenon, 3 lines, active high
      step(1,0,0, 0,1,1, "R2 R3 accept");
      step(1,0,0, 0,1,0, "R3 clr single cycle");
      step(0,0,1, 0,1,0, "R5 line before frame");
      step(0,1,0, 0,1,0, "R5 frame no pulse yet");
      step(0,0,0, 0,1,0, "R5 waiting line");
      step(0,0,1, 1,1,0, "R5 pulse start");
      step(1,0,0, 1,1,0, "R8 edge while busy");
      step(1,0,1, 1,1,0, "R5 line 2");
      step(1,0,1, 1,1,0, "R5 line 3");
      step(1,0,1, 0,0,0, "R5 R9 end after 3 lines");
      step(1,0,0, 0,0,0, "R2 R8 held level no retrigger");
      step(0,0,0, 0,0,0, "R9 idle");

      // xenon, 4 lines, active low
      setcfg(0, 2'b00, 2'd3, 16'd0);
      step(0,0,0, 0,0,0, "R4 idle level low polarity");
      step(1,0,0, 0,1,1, "R2 accept");
      step(0,1,1, 0,1,0, "R5 coinciding line ignored");
      step(0,0,1, 1,1,0, "R4 R5 active low start");
      step(0,0,1, 1,1,0, "R5 line 2");
      step(0,0,1, 1,1,0, "R5 line 3");
      step(0,0,1, 1,1,0, "R5 line 4");
      step(0,0,1, 0,0,0, "R5 end after 4 lines");

      // xenon, 1 line
      setcfg(1, 2'b00, 2'd0, 16'd0);
      step(1,0,0, 0,1,1, "R2 accept");
      step(0,1,0, 0,1,0, "R5 frame");
      step(0,0,1, 1,1,0, "R5 single line start");
      step(0,0,1, 0,0,0, "R5 single line end");

      // paired LED mode 01, width 2
      setcfg(1, 2'b01, 2'd3, 16'd2);
      step(1,0,0, 0,1,1, "R2 accept");
      step(0,0,1, 0,1,0, "R6 line before frame");
      step(0,1,0, 1,1,0, "R6 start at frame");
      step(0,0,1, 1,1,0, "R6 line 1");
      step(0,0,1, 0,0,0, "R6 end after 2 lines");

      // paired LED mode 10, width 1
      setcfg(1, 2'b10, 2'd0, 16'd1);
      step(1,0,0, 0,1,1, "R2 accept");
      step(0,1,0, 1,1,0, "R6 mode10 start");
      step(0,0,1, 0,0,0, "R6 mode10 end");

      // paired LED width zero
      setcfg(1, 2'b01, 2'd0, 16'd0);
      step(1,0,0, 0,1,1, "R2 accept");
      step(0,1,0, 0,0,0, "R6 zero width no pulse");

      // single LED, one frame
      setcfg(1, 2'b11, 2'd0, 16'd5);
      step(1,0,0, 0,1,1, "R2 accept");
      step(0,0,1, 0,1,0, "R7 waits frame");
      step(0,1,0, 1,1,0, "R7 start at frame");
      step(0,0,1, 1,1,0, "R7 line no effect");
      step(0,0,1, 1,1,0, "R7 line no effect 2");
      step(0,1,0, 0,0,0, "R7 end at next frame");
      step(0,0,0, 0,0,0, "R9 idle after frame");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule